// File: doc/BRIEF.md
# I3C Target Inverting Loopback Queue

This block is the back end of an I3C test target. It sits behind a byte-level transaction front end that has already decoded the bus. That front end hands over private-write bytes, read-byte requests, common-command opcodes and dynamic-address events. Every written byte is queued in an internal byte FIFO. When the inverting loopback option is enabled, each read takes the oldest queued byte and returns its bitwise complement. When the queue is empty, or the option is disabled, a read returns a constant byte set by a parameter.

The block also keeps the target's dynamic address. An address-assignment event sets it, and the broadcast reset-address command clears it. For a small set of GET commands, the matching response bytes are queued through the same FIFO, so the controller reads them back inverted in the same way as written data. Elaboration checks reject these settings:

- a FIFO depth that is not a power of two;
- an identifier value that is not one of the supported ones;
- a characteristic byte that is not one of the supported ones.

Top module: `i3c_tgt_loopfifo`

## Requirements
- R1: `wr_valid` pushes `wr_data` into a byte FIFO of `DEPTH` (default 2048) entries, and bytes leave it in the order they were written.
- R2: With `INV_LOOPBACK`=1 and the FIFO not empty, `rd_req` pops the oldest byte. The cycle after the request, `rd_valid` is 1 and `rd_data` is the bitwise NOT of that byte.
- R3: With `INV_LOOPBACK`=1 and the FIFO empty, a read returns `READ_VALUE` (default 0xA5), one cycle after `rd_req`.
- R4: With `INV_LOOPBACK`=0 (the default), every read returns `READ_VALUE` and nothing is popped.
- R5: The opcodes 0x8B and 0x8C each queue two bytes giving `DEPTH` as 16 bits, most significant byte first (0x08, 0x00 by default). Opcode 0x8E queues one byte equal to `BCR`, and opcode 0x8F queues one byte equal to `DCR`.
- R6: Opcode 0x8D queues the low 48 bits of `PID` as six bytes, most significant byte first. Bits 63:48 of `PID` have no effect.
- R7: Response bytes are queued one per cycle, starting the cycle after the opcode strobe. In any cycle where `wr_valid` is 1, the written byte takes that cycle's slot and the response resumes afterwards. While response bytes are pending, an opcode strobe is ignored. An opcode not listed in R5, R6 or R9 is ignored.
- R8: `daa_valid` while no address is held sets `dyn_addr` to `daa_addr` and raises `dyn_addr_valid` on the next cycle. While an address is held, `daa_valid` has no effect.
- R9: Opcode 0x06 clears `dyn_addr_valid` and `overflow` on the next cycle, and leaves the FIFO contents intact. It wins over a `daa_valid` or an overflow event in the same cycle.
- R10: A byte pushed while the FIFO holds `DEPTH` entries is dropped and sets `overflow`. The flag stays set until reset or opcode 0x06.
- R11: After reset the FIFO is empty, `rd_valid`, `dyn_addr_valid` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write-byte strobe |
| wr_data | input | 8 | Written byte |
| rd_req | input | 1 | Read-byte request |
| rd_valid | output | 1 | Read byte valid, one cycle after `rd_req` |
| rd_data | output | 8 | Read byte |
| ccc_valid | input | 1 | Common-command opcode strobe |
| ccc_code | input | 8 | Common-command opcode |
| daa_valid | input | 1 | Dynamic-address assignment event |
| daa_addr | input | 7 | Address offered by the assignment |
| dyn_addr_valid | output | 1 | A dynamic address is held |
| dyn_addr | output | 7 | Held dynamic address |
| overflow | output | 1 | Sticky dropped-byte flag |

## Verification
The main loopback function is tried with several input patterns, and each one separates a different fault:

- **Reads from an empty queue** separate the constant path from the inverting path.
- **Short write bursts followed by over-reads** expose ordering errors and a missing fallback.
- **A write and a read in the same cycle** test whether push and pop interfere.
- **Response commands with writes slipped into their slots**, and commands arriving while a response is pending, check the arbitration order.
- **Filling the queue past its depth** and then resetting the address separates the overflow flag from the queue contents.

A second instance with loopback disabled receives the same stimulus. It must return the constant byte on every read.

// File: rtl/i3c_lb_pkg.sv
package i3c_lb_pkg;

   localparam int          BYTE_W   = 8;
   localparam int          DADDR_W  = 7;
   localparam int          ID_W     = 48;

   localparam logic [7:0]  OP_RSTADDR = 8'h06;
   localparam logic [7:0]  OP_MAXWR   = 8'h8B;
   localparam logic [7:0]  OP_MAXRD   = 8'h8C;
   localparam logic [7:0]  OP_ID      = 8'h8D;
   localparam logic [7:0]  OP_BUSCHAR = 8'h8E;
   localparam logic [7:0]  OP_DEVCHAR = 8'h8F;

   function automatic bit id_is_legal(input logic [ID_W-1:0] id);
      return (id == 48'hFB1122330001) || (id == 48'hFB1122330002) ||
             (id == 48'hFB1122330003) || (id == 48'hFB1122550001);
   endfunction

   function automatic bit devchar_is_legal(input logic [7:0] dc);
      return (dc == 8'hE1) || (dc == 8'hE2) || (dc == 8'hE3) || (dc == 8'hC6);
   endfunction

endpackage

// File: rtl/lb_byte_fifo.sv
module lb_byte_fifo #(
   parameter  int DEPTH = 2048,
   parameter  int DW    = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [DW-1:0] pop_data,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr_q, rptr_q;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr_q] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (do_pop) pop_data <= mem[rptr_q];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         count  <= '0;
      end else begin
         if (do_push) wptr_q <= wptr_q + 1'b1;
         if (do_pop)  rptr_q <= rptr_q + 1'b1;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

endmodule

// File: rtl/lb_ccc_resp.sv
module lb_ccc_resp
   import i3c_lb_pkg::*;
#(
   parameter logic [ID_W-1:0] ID_VAL   = 48'hFB1122330001,
   parameter logic [7:0]      BUSCHAR  = 8'h06,
   parameter logic [7:0]      DEVCHAR  = 8'hE1,
   parameter logic [15:0]     MAXLEN   = 16'd2048
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        op_valid,
   input  logic [7:0]  op_code,
   input  logic        stall,
   output logic        push,
   output logic [7:0]  push_byte
);

   localparam int LEN_W = $clog2(ID_W / BYTE_W + 1);

   logic [ID_W-1:0]  shift_q;
   logic [LEN_W-1:0] left_q;
   logic             busy;

   assign busy      = (left_q != '0);
   assign push      = busy && !stall;
   assign push_byte = shift_q[ID_W-1 -: BYTE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         left_q  <= '0;
      end else if (!busy) begin
         if (op_valid) begin
            unique case (op_code)
               OP_MAXWR, OP_MAXRD: begin
                  shift_q <= {MAXLEN, {(ID_W-16){1'b0}}};
                  left_q  <= LEN_W'(2);
               end
               OP_ID: begin
                  shift_q <= ID_VAL;
                  left_q  <= LEN_W'(ID_W / BYTE_W);
               end
               OP_BUSCHAR: begin
                  shift_q <= {BUSCHAR, {(ID_W-BYTE_W){1'b0}}};
                  left_q  <= LEN_W'(1);
               end
               OP_DEVCHAR: begin
                  shift_q <= {DEVCHAR, {(ID_W-BYTE_W){1'b0}}};
                  left_q  <= LEN_W'(1);
               end
               default: ;
            endcase
         end
      end else if (!stall) begin
         shift_q <= {shift_q[ID_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
         left_q  <= left_q - 1'b1;
      end
   end

endmodule

// File: rtl/lb_read_path.sv
module lb_read_path #(
   parameter bit         INV_LOOPBACK = 1'b0,
   parameter logic [7:0] READ_VALUE   = 8'hA5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_req,
   input  logic       fifo_empty,
   input  logic [7:0] fifo_dout,
   output logic       fifo_pop,
   output logic       rd_valid,
   output logic [7:0] rd_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_valid <= 1'b0;
      else        rd_valid <= rd_req;
   end

   generate
      if (INV_LOOPBACK) begin : g_invert
         logic took_q;
         assign fifo_pop = rd_req && !fifo_empty;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) took_q <= 1'b0;
            else        took_q <= fifo_pop;
         end
         assign rd_data = took_q ? ~fifo_dout : READ_VALUE;
      end else begin : g_const
         logic unused_fifo_side;
         assign unused_fifo_side = fifo_empty ^ (^fifo_dout);
         assign fifo_pop = 1'b0;
         assign rd_data  = READ_VALUE;
      end
   endgenerate

endmodule

// File: rtl/i3c_tgt_loopfifo.sv
module i3c_tgt_loopfifo
   import i3c_lb_pkg::*;
#(
   parameter int          DEPTH        = 2048,
   parameter logic [63:0] PID          = 64'h0000_FB11_2233_0001,
   parameter logic [7:0]  DCR          = 8'hE1,
   parameter logic [7:0]  BCR          = 8'h06,
   parameter bit          INV_LOOPBACK = 1'b0,
   parameter logic [7:0]  READ_VALUE   = 8'hA5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_valid,
   input  logic [7:0]         wr_data,
   input  logic               rd_req,
   output logic               rd_valid,
   output logic [7:0]         rd_data,
   input  logic               ccc_valid,
   input  logic [7:0]         ccc_code,
   input  logic               daa_valid,
   input  logic [DADDR_W-1:0] daa_addr,
   output logic               dyn_addr_valid,
   output logic [DADDR_W-1:0] dyn_addr,
   output logic               overflow
);

   localparam int              CW      = $clog2(DEPTH) + 1;
   localparam logic [ID_W-1:0] ID_LOW  = PID[ID_W-1:0];
   localparam logic [15:0]     MAXLEN  = 16'(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (!id_is_legal(ID_LOW)) begin : g_bad_id
         $error("PID low 48 bits are not a supported identifier");
      end
      if (!devchar_is_legal(DCR)) begin : g_bad_dcr
         $error("DCR is not a supported characteristic byte");
      end
   endgenerate

   logic          addr_reset;
   logic          resp_push;
   logic [7:0]    resp_byte;
   logic          q_push;
   logic [7:0]    q_byte;
   logic          q_pop;
   logic [7:0]    q_dout;
   logic [CW-1:0] fifo_count;
   logic          q_full, q_empty;

   assign addr_reset = ccc_valid && (ccc_code == OP_RSTADDR);

   lb_ccc_resp #(
      .ID_VAL  (ID_LOW),
      .BUSCHAR (BCR),
      .DEVCHAR (DCR),
      .MAXLEN  (MAXLEN)
   ) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (ccc_valid),
      .op_code   (ccc_code),
      .stall     (wr_valid),
      .push      (resp_push),
      .push_byte (resp_byte)
   );

   assign q_push = wr_valid || resp_push;
   assign q_byte = wr_valid ? wr_data : resp_byte;

   lb_byte_fifo #(
      .DEPTH (DEPTH),
      .DW    (BYTE_W)
   ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (q_push),
      .push_data (q_byte),
      .pop       (q_pop),
      .pop_data  (q_dout),
      .count     (fifo_count),
      .full      (q_full),
      .empty     (q_empty)
   );

   lb_read_path #(
      .INV_LOOPBACK (INV_LOOPBACK),
      .READ_VALUE   (READ_VALUE)
   ) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_req     (rd_req),
      .fifo_empty (q_empty),
      .fifo_dout  (q_dout),
      .fifo_pop   (q_pop),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 overflow <= 1'b0;
      else if (addr_reset)        overflow <= 1'b0;
      else if (q_push && q_full)  overflow <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dyn_addr_valid <= 1'b0;
         dyn_addr       <= '0;
      end else if (addr_reset) begin
         dyn_addr_valid <= 1'b0;
      end else if (daa_valid && !dyn_addr_valid) begin
         dyn_addr_valid <= 1'b1;
         dyn_addr       <= daa_addr;
      end
   end

endmodule

// File: rtl/lb_loopfifo_chk.sv
module lb_loopfifo_chk #(
   parameter int         DEPTH        = 2048,
   parameter bit         INV_LOOPBACK = 1'b0,
   parameter logic [7:0] READ_VALUE   = 8'hA5,
   parameter int         CW           = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_req,
   input logic          rd_valid,
   input logic [7:0]    rd_data,
   input logic          ccc_valid,
   input logic [7:0]    ccc_code,
   input logic          daa_valid,
   input logic [6:0]    daa_addr,
   input logic          dyn_addr_valid,
   input logic [6:0]    dyn_addr,
   input logic          overflow,
   input logic [CW-1:0] fifo_count
);

   logic rst_cmd;
   assign rst_cmd = ccc_valid && (ccc_code == 8'h06);

   p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_count <= CW'(DEPTH));

   p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);

   p_no_spurious_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_valid);

   p_empty_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && fifo_count == '0) |=> (rd_data == READ_VALUE));

   p_const_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!INV_LOOPBACK && rd_valid) |-> (rd_data == READ_VALUE));

   p_daa_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (daa_valid && !dyn_addr_valid && !rst_cmd) |=>
         (dyn_addr_valid && dyn_addr == $past(daa_addr)));

   p_daa_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dyn_addr_valid && !rst_cmd) |=> (dyn_addr_valid && $stable(dyn_addr)));

   p_addr_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_cmd |=> (!dyn_addr_valid && !overflow));

   p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !rst_cmd) |=> overflow);

endmodule

bind i3c_tgt_loopfifo lb_loopfifo_chk #(
   .DEPTH        (DEPTH),
   .INV_LOOPBACK (INV_LOOPBACK),
   .READ_VALUE   (READ_VALUE),
   .CW           (CW)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .rd_req         (rd_req),
   .rd_valid       (rd_valid),
   .rd_data        (rd_data),
   .ccc_valid      (ccc_valid),
   .ccc_code       (ccc_code),
   .daa_valid      (daa_valid),
   .daa_addr       (daa_addr),
   .dyn_addr_valid (dyn_addr_valid),
   .dyn_addr       (dyn_addr),
   .overflow       (overflow),
   .fifo_count     (fifo_count)
);

// File: tb/i3c_tgt_loopfifo_tb_top.sv
module i3c_tgt_loopfifo_tb_top;

   localparam int          CLK_PERIOD = 10;
   localparam int          DEPTH      = 2048;
   localparam logic [63:0] PID        = 64'h0000_FB11_2233_0001;
   localparam logic [7:0]  DCR        = 8'hE1;
   localparam logic [7:0]  BCR        = 8'h06;
   localparam logic [7:0]  RV         = 8'hA5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_valid = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_req = 1'b0;
   logic       ccc_valid = 1'b0;
   logic [7:0] ccc_code = '0;
   logic       daa_valid = 1'b0;
   logic [6:0] daa_addr = '0;

   logic       rd_valid, dav, ovf;
   logic [7:0] rd_data;
   logic [6:0] dyn_addr;
   logic       c_rd_valid, c_dav, c_ovf;
   logic [7:0] c_rd_data;
   logic [6:0] c_dyn_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   i3c_tgt_loopfifo #(
      .DEPTH(DEPTH), .PID(PID), .DCR(DCR), .BCR(BCR),
      .INV_LOOPBACK(1'b1), .READ_VALUE(RV)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
      .ccc_valid(ccc_valid), .ccc_code(ccc_code),
      .daa_valid(daa_valid), .daa_addr(daa_addr),
      .dyn_addr_valid(dav), .dyn_addr(dyn_addr), .overflow(ovf)
   );

   i3c_tgt_loopfifo dut_const_i (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .rd_req(rd_req), .rd_valid(c_rd_valid), .rd_data(c_rd_data),
      .ccc_valid(ccc_valid), .ccc_code(ccc_code),
      .daa_valid(daa_valid), .daa_addr(daa_addr),
      .dyn_addr_valid(c_dav), .dyn_addr(c_dyn_addr), .overflow(c_ovf)
   );

   int checks = 0;
   int failures = 0;
   string cur_req = "R11";

   logic [7:0] q[$];
   logic [7:0] sq[$];
   bit         m_av = 0;
   logic [6:0] m_addr = '0;
   bit         m_ovf = 0;
   bit         e_rv = 0;
   logic [7:0] e_rd = '0;
   bit         e_c_rv = 0;

   task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
      end
   endtask

   task automatic model_step();
      bit         rst_c = ccc_valid && (ccc_code == 8'h06);
      bit         busy  = (sq.size() != 0);
      bit         full  = (q.size() == DEPTH);
      bit         has_push = 0;
      logic [7:0] pb = '0;
      e_rv   = rd_req;
      e_c_rv = rd_req;
      if (rd_req && q.size() != 0) e_rd = ~q.pop_front();
      else                         e_rd = RV;
      if (wr_valid)  begin has_push = 1; pb = wr_data; end
      else if (busy) begin has_push = 1; pb = sq.pop_front(); end
      if (has_push) begin
         if (full) m_ovf = 1;
         else      q.push_back(pb);
      end
      if (ccc_valid && !busy) begin
         case (ccc_code)
            8'h8B, 8'h8C: sq = '{8'(DEPTH >> 8), 8'(DEPTH)};
            8'h8D: sq = '{PID[47:40], PID[39:32], PID[31:24], PID[23:16], PID[15:8], PID[7:0]};
            8'h8E: sq = '{BCR};
            8'h8F: sq = '{DCR};
            default: ;
         endcase
      end
      if (daa_valid && !rst_c && !m_av) begin m_av = 1; m_addr = daa_addr; end
      if (rst_c) begin m_av = 0; m_ovf = 0; end
   endtask

   task automatic compare();
      chk("rd_valid", {7'b0, rd_valid}, {7'b0, e_rv});
      if (e_rv) chk("rd_data", rd_data, e_rd);
      chk("dyn_addr_valid", {7'b0, dav}, {7'b0, m_av});
      if (m_av) chk("dyn_addr", {1'b0, dyn_addr}, {1'b0, m_addr});
      chk("overflow", {7'b0, ovf}, {7'b0, m_ovf});
      checks++;
      if (c_rd_valid !== e_c_rv || (e_c_rv && c_rd_data !== RV)) begin
         failures++;
         $display("FAIL R4 const-read act=%b/%h exp=%b/%h", c_rd_valid, c_rd_data, e_c_rv, RV);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      model_step();
      compare();
      wr_valid = 0; rd_req = 0; ccc_valid = 0; daa_valid = 0;
   endtask

   task automatic do_wr(input logic [7:0] b);
      wr_valid = 1; wr_data = b; cyc();
   endtask

   task automatic do_rd(input int n);
      for (int i = 0; i < n; i++) begin rd_req = 1; cyc(); end
   endtask

   task automatic do_ccc(input logic [7:0] op);
      ccc_valid = 1; ccc_code = op; cyc();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++; checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      // R11: reset state
      cur_req = "R11";
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare();
      rst_n = 1;
      cyc();

      cur_req = "R3";
      do_rd(2);

      cur_req = "R1";
      do_wr(8'h11); do_wr(8'h22); do_wr(8'h33);
      cur_req = "R2";
      do_rd(4);

      // write and read in the same cycle
      do_wr(8'h5A);
      wr_valid = 1; wr_data = 8'hC3; rd_req = 1; cyc();
      do_rd(2);

      cur_req = "R6";
      do_ccc(8'h8D);
      repeat (6) cyc();
      do_rd(7);

      cur_req = "R5";
      do_ccc(8'h8B); cyc(); cyc();
      do_ccc(8'h8C); cyc(); cyc();
      do_ccc(8'h8E); cyc();
      do_ccc(8'h8F); cyc();
      do_rd(7);

      cur_req = "R7";
      do_ccc(8'h42); cyc();
      do_rd(1);
      do_ccc(8'h8F); do_wr(8'h0F); cyc();
      do_rd(3);
      do_ccc(8'h8D); do_ccc(8'h8E);
      repeat (6) cyc();
      do_rd(8);
      do_ccc(8'h8B); do_wr(8'h01); do_wr(8'h02); cyc(); cyc();
      do_rd(5);

      cur_req = "R8";
      daa_valid = 1; daa_addr = 7'h3A; cyc();
      daa_valid = 1; daa_addr = 7'h11; cyc();
      cyc();
      cur_req = "R9";
      do_ccc(8'h06);
      ccc_valid = 1; ccc_code = 8'h06; daa_valid = 1; daa_addr = 7'h22; cyc();
      cur_req = "R8";
      daa_valid = 1; daa_addr = 7'h45; cyc();
      cyc();

      cur_req = "R10";
      for (int i = 0; i < DEPTH + 3; i++) do_wr(8'(i * 7 + 3));
      cyc();
      cur_req = "R9";
      do_ccc(8'h06);
      cyc();
      cur_req = "R10";
      do_wr(8'hEE);
      cur_req = "R9";
      do_rd(3);
      cur_req = "R10";
      do_wr(8'h77);
      do_wr(8'h78);
      cur_req = "R1";
      do_rd(DEPTH + 2);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule